// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits in front of a single-shot AUX channel engine and owns the retry policy for one request. When a request is accepted it pulses the engine start, waits for the engine's outcome, and sorts that outcome into a class. The classes are a reply with a reply code, an invalid reply, a timeout, a lost connection and a failed engine grab. Each class has its own retry counter and back-off. The block then either relaunches the engine after the proper wait or ends the request with a one-cycle done strobe and a pass/fail flag.

Waits are counted on an external microsecond tick. Defer waits are programmed in milliseconds through `defer_ms`. Native defers also add `poll_ms` to an accumulated defer time. When a write is answered with an ACK that still reports pending bytes, the controller rewrites its own command into a zero-length write-status request. Later attempts of that request use the rewritten command.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, `eng_start`, `busy`, `done` and `ok` are all low.
- R2: A request accepted while idle gives a one-cycle `eng_start` with `cmd_write`/`cmd_len` equal to the request. Each request ends with `done` high for exactly one cycle, and `ok` is high only with `done` and only after a full ACK. Encodings: `eng_status` 0 = reply received, 1 = invalid reply, 2 = timeout, 3 = disconnect, 4 = acquire error. `eng_reply` 0 = ACK, 1 = native NACK, 2 = native defer, 4 = I2C NACK, 8 = I2C defer.
- R3: No request makes more than 7 engine attempts; a retry that would be the 8th ends the request failed.
- R4: An invalid reply is retried after 400 µs; the second invalid reply fails the request.
- R5: A timeout with no earlier defer in the request is retried with no wait; the third such timeout fails the request.
- R6: Any received reply (status 0) clears the timeout and invalid-reply counters.
- R7: A native defer bumps the defer count and adds `poll_ms` to the defer time. It fails only when the count is at least 7 and the time is at least 50 ms. Otherwise it waits `defer_ms` ms and adds that to the defer time.
- R8: An I2C defer zeroes the native defer count, waits `defer_ms` ms, and fails on the 7th I2C defer.
- R9: A timeout after any earlier defer counts as a native defer: it waits `defer_ms` ms and fails when that count reaches 7.
- R10: A read ACK whose byte count differs from the requested length is retried after 300 µs, failing on the 7th.
- R11: A write ACK with a non-zero byte count retries after 300 µs as a write-status request (`cmd_write`=0, `cmd_status_req`=1, `cmd_len`=0), limit 7.
- R12: A native NACK, I2C NACK, unknown reply code, disconnect or acquire error fails the request with no retry.
- R13: With `us_tick` high every cycle, a retry after a wait of W µs raises `eng_start` W+2 cycles after the cycle in which `eng_done` was high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Start a request (taken only when idle) |
| req_write | input | 1 | Request is a write |
| req_i2c | input | 1 | Request is I2C over AUX |
| req_mot | input | 1 | Middle-of-transaction flag |
| req_len | input | LEN_W | Requested byte count |
| defer_ms | input | MS_W | Wait after a defer, in ms |
| poll_ms | input | MS_W | Engine polling period, in ms |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| eng_done | input | 1 | Engine outcome valid |
| eng_status | input | 3 | Engine outcome class |
| eng_reply | input | 4 | Reply code from the sink |
| eng_bytes | input | LEN_W | Bytes returned after the reply code |
| eng_start | output | 1 | Launch the engine |
| cmd_write | output | 1 | Current command is a write |
| cmd_i2c | output | 1 | Current command is I2C over AUX |
| cmd_mot | output | 1 | Current middle-of-transaction flag |
| cmd_status_req | output | 1 | Current command is a write-status poll |
| cmd_len | output | LEN_W | Current command length |
| busy | output | 1 | A request is in progress |
| done | output | 1 | Request finished (one cycle) |
| ok | output | 1 | Request passed, valid with done |
| | | | |

## Verification
The assertions assume that the engine answers once per launch. `eng_done` comes only while the controller is waiting on that launch. The defer and poll inputs stay steady during a request. The bench's engine stub meets this by answering each observed `eng_start` exactly three cycles later with a single scripted outcome. It then stays silent until the next start, and it holds `defer_ms` and `poll_ms` constant. Each scripted outcome sequence is matched to the expected command per attempt, the expected gap before each relaunch and the final verdict. This lets the wait lengths, the command rewrite and the per-class limits be checked at the ports.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

  localparam logic [2:0] ST_REPLY   = 3'd0;
  localparam logic [2:0] ST_INVALID = 3'd1;
  localparam logic [2:0] ST_TIMEOUT = 3'd2;
  localparam logic [2:0] ST_DISCON  = 3'd3;
  localparam logic [2:0] ST_ACQERR  = 3'd4;

  localparam logic [3:0] RP_ACK       = 4'h0;
  localparam logic [3:0] RP_NACK      = 4'h1;
  localparam logic [3:0] RP_DEFER     = 4'h2;
  localparam logic [3:0] RP_I2C_NACK  = 4'h4;
  localparam logic [3:0] RP_I2C_DEFER = 4'h8;

  typedef enum logic [1:0] {V_RETRY, V_PASS, V_FAIL} verdict_e;

  typedef enum logic [2:0] {
    S_IDLE, S_LAUNCH, S_WAIT, S_DELAY, S_FIN
  } ctrl_state_e;

endpackage

// File: rtl/aux_wait_timer.sv
module aux_wait_timer #(
  parameter int TMR_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             tick,
  output logic             expired
);

  logic [TMR_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (tick && (cnt_q != '0))
      cnt_d = cnt_q - TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);

  // Wait lengths are counted one microsecond tick at a time (R13)
  p_tick_countdown_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - TMR_W'(1)));

  p_hold_no_tick_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/aux_retry_policy.sv
module aux_retry_policy
  import aux_retry_pkg::*;
#(
  parameter int LEN_W          = 8,
  parameter int MS_W           = 8,
  parameter int MAX_ATTEMPTS   = 7,
  parameter int INV_LIMIT      = 2,
  parameter int TMO_LIMIT      = 3,
  parameter int DEFER_LIMIT    = 7,
  parameter int I2C_DEF_LIMIT  = 7,
  parameter int ACK_LIMIT      = 7,
  parameter int DEFER_TIME_MS  = 50,
  parameter int INV_WAIT_US    = 400,
  parameter int ACK_WAIT_US    = 300,
  parameter int TMR_W          = MS_W + 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             eval,
  input  logic [2:0]       status,
  input  logic [3:0]       reply,
  input  logic [LEN_W-1:0] bytes,
  input  logic             cur_write,
  input  logic [LEN_W-1:0] cur_len,
  input  logic [MS_W-1:0]  defer_ms,
  input  logic [MS_W-1:0]  poll_ms,
  output verdict_e         verdict,
  output logic [TMR_W-1:0] wait_us,
  output logic             go_poll
);

  localparam int L1 = (MAX_ATTEMPTS > INV_LIMIT) ? MAX_ATTEMPTS : INV_LIMIT;
  localparam int L2 = (L1 > TMO_LIMIT) ? L1 : TMO_LIMIT;
  localparam int L3 = (L2 > DEFER_LIMIT) ? L2 : DEFER_LIMIT;
  localparam int L4 = (L3 > I2C_DEF_LIMIT) ? L3 : I2C_DEF_LIMIT;
  localparam int LIM_TOP = (L4 > ACK_LIMIT) ? L4 : ACK_LIMIT;
  localparam int CNT_W = $clog2(LIM_TOP + 2);
  localparam int ACC_W = MS_W + CNT_W + 2;

  logic [CNT_W-1:0] att_q, inv_q, tmo_q, dcnt_q, idef_q, ack_q, ackm_q;
  logic [CNT_W-1:0] att_n, inv_n, tmo_n, dcnt_n, idef_n, ack_n, ackm_n;
  logic [ACC_W-1:0] acc_q, acc_n, acc_poll;
  logic             seen_q, seen_n;
  verdict_e         raw_v;
  logic [TMR_W-1:0] raw_wait, defer_us;
  logic             raw_poll;

  assign defer_us = TMR_W'(defer_ms) * TMR_W'(1000);
  assign acc_poll = acc_q + ACC_W'(poll_ms);

  always_comb begin
    inv_n    = inv_q;
    tmo_n    = tmo_q;
    dcnt_n   = dcnt_q;
    idef_n   = idef_q;
    ack_n    = ack_q;
    ackm_n   = ackm_q;
    acc_n    = acc_q;
    seen_n   = seen_q;
    raw_v    = V_FAIL;
    raw_wait = '0;
    raw_poll = 1'b0;
    case (status)
      ST_REPLY: begin
        tmo_n = '0;
        inv_n = '0;
        case (reply)
          RP_ACK: begin
            if (!cur_write && (bytes != cur_len)) begin
              ack_n = ack_q + CNT_W'(1);
              if (ack_n < CNT_W'(ACK_LIMIT)) begin
                raw_v    = V_RETRY;
                raw_wait = TMR_W'(ACK_WAIT_US);
              end
            end else if (cur_write && (bytes != '0)) begin
              ackm_n = ackm_q + CNT_W'(1);
              if (ackm_n < CNT_W'(ACK_LIMIT)) begin
                raw_v    = V_RETRY;
                raw_wait = TMR_W'(ACK_WAIT_US);
                raw_poll = 1'b1;
              end
            end else begin
              raw_v = V_PASS;
            end
          end
          RP_DEFER: begin
            dcnt_n = dcnt_q + CNT_W'(1);
            seen_n = 1'b1;
            if ((dcnt_n >= CNT_W'(DEFER_LIMIT)) &&
                (acc_poll >= ACC_W'(DEFER_TIME_MS))) begin
              acc_n = acc_poll;
            end else begin
              raw_v    = V_RETRY;
              raw_wait = defer_us;
              acc_n    = acc_poll + ACC_W'(defer_ms);
            end
          end
          RP_I2C_DEFER: begin
            dcnt_n = '0;
            idef_n = idef_q + CNT_W'(1);
            seen_n = 1'b1;
            if (idef_n < CNT_W'(I2C_DEF_LIMIT)) begin
              raw_v    = V_RETRY;
              raw_wait = defer_us;
              acc_n    = acc_q + ACC_W'(defer_ms);
            end
          end
          default: raw_v = V_FAIL;
        endcase
      end
      ST_INVALID: begin
        inv_n = inv_q + CNT_W'(1);
        if (inv_n < CNT_W'(INV_LIMIT)) begin
          raw_v    = V_RETRY;
          raw_wait = TMR_W'(INV_WAIT_US);
        end
      end
      ST_TIMEOUT: begin
        if (seen_q) begin
          dcnt_n = dcnt_q + CNT_W'(1);
          if (dcnt_n < CNT_W'(DEFER_LIMIT)) begin
            raw_v    = V_RETRY;
            raw_wait = defer_us;
            acc_n    = acc_q + ACC_W'(defer_ms);
          end
        end else begin
          tmo_n = tmo_q + CNT_W'(1);
          if (tmo_n < CNT_W'(TMO_LIMIT)) begin
            raw_v    = V_RETRY;
            raw_wait = '0;
          end
        end
      end
      default: raw_v = V_FAIL;
    endcase

    att_n   = att_q + CNT_W'(1);
    verdict = raw_v;
    go_poll = raw_poll;
    wait_us = raw_wait;
    if ((raw_v == V_RETRY) && (att_n >= CNT_W'(MAX_ATTEMPTS))) begin
      verdict = V_FAIL;
      go_poll = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      att_q  <= '0;
      inv_q  <= '0;
      tmo_q  <= '0;
      dcnt_q <= '0;
      idef_q <= '0;
      ack_q  <= '0;
      ackm_q <= '0;
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (clear) begin
      att_q  <= '0;
      inv_q  <= '0;
      tmo_q  <= '0;
      dcnt_q <= '0;
      idef_q <= '0;
      ack_q  <= '0;
      ackm_q <= '0;
      acc_q  <= '0;
      seen_q <= 1'b0;
    end else if (eval) begin
      att_q  <= att_n;
      inv_q  <= inv_n;
      tmo_q  <= tmo_n;
      dcnt_q <= dcnt_n;
      idef_q <= idef_n;
      ack_q  <= ack_n;
      ackm_q <= ackm_n;
      acc_q  <= acc_n;
      seen_q <= seen_n;
    end
  end

  p_attempt_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    att_q <= CNT_W'(MAX_ATTEMPTS));

  p_invalid_limit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && status == ST_INVALID && inv_q == CNT_W'(INV_LIMIT - 1))
      |-> (verdict == V_FAIL));

  p_timeout_nowait_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && verdict == V_RETRY && status == ST_TIMEOUT && !seen_q)
      |-> (wait_us == '0));

  p_reply_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && status == ST_REPLY) |=> (tmo_q == '0 && inv_q == '0));

  p_i2c_defer_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && status == ST_REPLY && reply == RP_I2C_DEFER) |=> (dcnt_q == '0));

  p_hard_fail_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && (status == ST_DISCON || status == ST_ACQERR)) |-> (verdict == V_FAIL));

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
  import aux_retry_pkg::*;
#(
  parameter int LEN_W         = 8,
  parameter int MS_W          = 8,
  parameter int MAX_ATTEMPTS  = 7,
  parameter int INV_LIMIT     = 2,
  parameter int TMO_LIMIT     = 3,
  parameter int DEFER_LIMIT   = 7,
  parameter int I2C_DEF_LIMIT = 7,
  parameter int ACK_LIMIT     = 7,
  parameter int DEFER_TIME_MS = 50,
  parameter int INV_WAIT_US   = 400,
  parameter int ACK_WAIT_US   = 300
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic             req_i2c,
  input  logic             req_mot,
  input  logic [LEN_W-1:0] req_len,
  input  logic [MS_W-1:0]  defer_ms,
  input  logic [MS_W-1:0]  poll_ms,
  input  logic             us_tick,
  input  logic             eng_done,
  input  logic [2:0]       eng_status,
  input  logic [3:0]       eng_reply,
  input  logic [LEN_W-1:0] eng_bytes,
  output logic             eng_start,
  output logic             cmd_write,
  output logic             cmd_i2c,
  output logic             cmd_mot,
  output logic             cmd_status_req,
  output logic [LEN_W-1:0] cmd_len,
  output logic             busy,
  output logic             done,
  output logic             ok
);

  localparam int TMR_W = MS_W + 10;

  ctrl_state_e      state_q, state_d;
  logic             ok_q, ok_d;
  logic             wr_q, wr_d, i2c_q, i2c_d, mot_q, mot_d, sreq_q, sreq_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic             accept, eval, expired, go_poll;
  verdict_e         verdict;
  logic [TMR_W-1:0] wait_us;

  assign accept = (state_q == S_IDLE) && req_valid;
  assign eval   = (state_q == S_WAIT) && eng_done;

  aux_retry_policy #(
    .LEN_W(LEN_W), .MS_W(MS_W), .MAX_ATTEMPTS(MAX_ATTEMPTS),
    .INV_LIMIT(INV_LIMIT), .TMO_LIMIT(TMO_LIMIT), .DEFER_LIMIT(DEFER_LIMIT),
    .I2C_DEF_LIMIT(I2C_DEF_LIMIT), .ACK_LIMIT(ACK_LIMIT),
    .DEFER_TIME_MS(DEFER_TIME_MS), .INV_WAIT_US(INV_WAIT_US),
    .ACK_WAIT_US(ACK_WAIT_US), .TMR_W(TMR_W)
  ) u_policy (
    .clk(clk), .rst_n(rst_n), .clear(accept), .eval(eval),
    .status(eng_status), .reply(eng_reply), .bytes(eng_bytes),
    .cur_write(wr_q), .cur_len(len_q), .defer_ms(defer_ms), .poll_ms(poll_ms),
    .verdict(verdict), .wait_us(wait_us), .go_poll(go_poll)
  );

  aux_wait_timer #(.TMR_W(TMR_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(eval), .load_val(wait_us),
    .tick(us_tick), .expired(expired)
  );

  always_comb begin
    state_d = state_q;
    ok_d    = ok_q;
    case (state_q)
      S_IDLE:   if (accept) state_d = S_LAUNCH;
      S_LAUNCH: state_d = S_WAIT;
      S_WAIT: begin
        if (eval) begin
          ok_d    = (verdict == V_PASS);
          state_d = (verdict == V_RETRY) ? S_DELAY : S_FIN;
        end
      end
      S_DELAY:  if (expired) state_d = S_LAUNCH;
      S_FIN:    state_d = S_IDLE;
      default:  state_d = S_IDLE;
    endcase
  end

  always_comb begin
    wr_d   = wr_q;
    i2c_d  = i2c_q;
    mot_d  = mot_q;
    sreq_d = sreq_q;
    len_d  = len_q;
    if (accept) begin
      wr_d   = req_write;
      i2c_d  = req_i2c;
      mot_d  = req_mot;
      sreq_d = 1'b0;
      len_d  = req_len;
    end else if (eval && go_poll) begin
      wr_d   = 1'b0;
      sreq_d = 1'b1;
      len_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      ok_q    <= 1'b0;
      wr_q    <= 1'b0;
      i2c_q   <= 1'b0;
      mot_q   <= 1'b0;
      sreq_q  <= 1'b0;
      len_q   <= '0;
    end else begin
      state_q <= state_d;
      ok_q    <= ok_d;
      wr_q    <= wr_d;
      i2c_q   <= i2c_d;
      mot_q   <= mot_d;
      sreq_q  <= sreq_d;
      len_q   <= len_d;
    end
  end

  assign eng_start      = (state_q == S_LAUNCH);
  assign busy           = (state_q != S_IDLE);
  assign done           = (state_q == S_FIN);
  assign ok             = done && ok_q;
  assign cmd_write      = wr_q;
  assign cmd_i2c        = i2c_q;
  assign cmd_mot        = mot_q;
  assign cmd_status_req = sreq_q;
  assign cmd_len        = len_q;

  p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  p_ok_with_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ok |-> done);

  p_engine_expected_r2: assert property (@(posedge clk) disable iff (!rst_n)
    eng_done |-> (state_q == S_WAIT));

  p_poll_shape_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_status_req |-> (!cmd_write && cmd_len == '0));

endmodule

// File: tb/tb_aux_retry_ctrl.sv
module tb_aux_retry_ctrl;

  logic       clk, rst_n;
  logic       req_valid, req_write, req_i2c, req_mot;
  logic [7:0] req_len, defer_ms, poll_ms;
  logic       us_tick, eng_done;
  logic [2:0] eng_status;
  logic [3:0] eng_reply;
  logic [7:0] eng_bytes;
  logic       eng_start, cmd_write, cmd_i2c, cmd_mot, cmd_status_req;
  logic [7:0] cmd_len;
  logic       busy, done, ok;

  aux_retry_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_i2c(req_i2c), .req_mot(req_mot), .req_len(req_len),
    .defer_ms(defer_ms), .poll_ms(poll_ms), .us_tick(us_tick),
    .eng_done(eng_done), .eng_status(eng_status), .eng_reply(eng_reply),
    .eng_bytes(eng_bytes), .eng_start(eng_start), .cmd_write(cmd_write),
    .cmd_i2c(cmd_i2c), .cmd_mot(cmd_mot), .cmd_status_req(cmd_status_req),
    .cmd_len(cmd_len), .busy(busy), .done(done), .ok(ok)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct { int gap; bit w; bit s; int len; } att_t;
  typedef struct { logic [2:0] st; logic [3:0] rp; int by; } rsp_t;
  typedef struct { bit ok; int att; } res_t;

  att_t  att_q[$];
  rsp_t  rsp_q[$];
  res_t  res_q[$];

  int    checks = 0, errors = 0;
  string tag = "R1";
  bit    cur_w;
  int    cur_len;
  int    gap_cnt = 0, seen_att = 0, resp_cd = 0;
  bit    done_evt = 0, finished = 0;

  task automatic check(bit cond, string t, int act, int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic begin_case(string t, bit w, int len);
    tag = t; cur_w = w; cur_len = len;
  endtask

  task automatic try_(int gap, logic [2:0] st, logic [3:0] rp, int by);
    att_t a; rsp_t r;
    a.gap = gap; a.w = cur_w; a.s = 1'b0; a.len = cur_len;
    r.st = st; r.rp = rp; r.by = by;
    att_q.push_back(a); rsp_q.push_back(r);
  endtask

  task automatic try_poll(int gap, logic [2:0] st, logic [3:0] rp, int by);
    att_t a; rsp_t r;
    a.gap = gap; a.w = 1'b0; a.s = 1'b1; a.len = 0;
    r.st = st; r.rp = rp; r.by = by;
    att_q.push_back(a); rsp_q.push_back(r);
  endtask

  task automatic run_case(bit exp_ok, int exp_att);
    res_t e;
    e.ok = exp_ok; e.att = exp_att;
    res_q.push_back(e);
    @(negedge clk);
    req_valid = 1'b1; req_write = cur_w; req_len = 8'(cur_len);
    req_i2c = 1'b1; req_mot = 1'b0;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done_evt) @(negedge clk);
    done_evt = 0;
    check(rsp_q.size() == 0, {tag, " engine responses used"}, rsp_q.size(), 0);
    repeat (3) @(negedge clk);
  endtask

  // Monitor and engine stub
  always @(negedge clk) begin
    if (rst_n) begin
      gap_cnt++;
      if (done) begin
        res_t e;
        e = res_q.pop_front();
        check(ok == e.ok, {tag, " verdict ok"}, int'(ok), int'(e.ok));
        check(seen_att == e.att, {tag, " attempt count"}, seen_att, e.att);
        seen_att = 0;
        done_evt = 1;
      end
      if (eng_start) begin
        att_t a;
        seen_att++;
        a = att_q.pop_front();
        if (a.gap >= 0)
          check(gap_cnt == a.gap, {tag, " relaunch gap R13"}, gap_cnt, a.gap);
        check(cmd_write == a.w, {tag, " cmd_write"}, int'(cmd_write), int'(a.w));
        check(cmd_status_req == a.s, {tag, " cmd_status_req"}, int'(cmd_status_req), int'(a.s));
        check(int'(cmd_len) == a.len, {tag, " cmd_len"}, int'(cmd_len), a.len);
        resp_cd = 3;
      end
      eng_done = 1'b0;
      if (resp_cd > 0) begin
        resp_cd--;
        if (resp_cd == 0) begin
          rsp_t r;
          r = rsp_q.pop_front();
          eng_done = 1'b1; eng_status = r.st; eng_reply = r.rp;
          eng_bytes = 8'(r.by);
          gap_cnt = 0;
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!finished && cyc < 150000) begin
      @(negedge clk);
      cyc++;
    end
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_i2c = 1'b0;
    req_mot = 1'b0; req_len = '0; defer_ms = 8'd1; poll_ms = 8'd10;
    us_tick = 1'b1; eng_done = 1'b0; eng_status = '0; eng_reply = '0;
    eng_bytes = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!eng_start && !busy && !done && !ok, "R1 idle after reset",
          int'({eng_start, busy, done, ok}), 0);

    begin_case("R2 full read ACK", 1'b0, 4);
    try_(-1, 3'd0, 4'h0, 4); run_case(1'b1, 1);
    begin_case("R2 full write ACK", 1'b1, 2);
    try_(-1, 3'd0, 4'h0, 0); run_case(1'b1, 1);

    begin_case("R12 native NACK", 1'b0, 1);
    try_(-1, 3'd0, 4'h1, 0); run_case(1'b0, 1);
    begin_case("R12 I2C NACK", 1'b0, 1);
    try_(-1, 3'd0, 4'h4, 0); run_case(1'b0, 1);
    begin_case("R12 unknown code", 1'b0, 1);
    try_(-1, 3'd0, 4'h3, 1); run_case(1'b0, 1);
    begin_case("R12 disconnect", 1'b0, 1);
    try_(-1, 3'd3, 4'h0, 1); run_case(1'b0, 1);
    begin_case("R12 acquire error", 1'b1, 1);
    try_(-1, 3'd4, 4'h0, 0); run_case(1'b0, 1);

    begin_case("R4 invalid then ACK", 1'b0, 4);
    try_(-1, 3'd1, 4'h0, 0); try_(402, 3'd0, 4'h0, 4); run_case(1'b1, 2);
    begin_case("R4 second invalid fails", 1'b0, 4);
    try_(-1, 3'd1, 4'h0, 0); try_(402, 3'd1, 4'h0, 0); run_case(1'b0, 2);

    begin_case("R5 third timeout fails", 1'b0, 2);
    try_(-1, 3'd2, 4'h0, 0); try_(2, 3'd2, 4'h0, 0); try_(2, 3'd2, 4'h0, 0);
    run_case(1'b0, 3);

    begin_case("R6 reply clears timeouts", 1'b0, 4);
    try_(-1, 3'd2, 4'h0, 0); try_(2, 3'd2, 4'h0, 0); try_(2, 3'd0, 4'h0, 0);
    try_(302, 3'd2, 4'h0, 0); try_(2, 3'd2, 4'h0, 0); try_(2, 3'd0, 4'h0, 4);
    run_case(1'b1, 6);
    begin_case("R6 reply clears invalids", 1'b0, 4);
    try_(-1, 3'd1, 4'h0, 0); try_(402, 3'd0, 4'h0, 1); try_(302, 3'd1, 4'h0, 0);
    try_(402, 3'd0, 4'h0, 4); run_case(1'b1, 4);

    begin_case("R3 attempt cap", 1'b0, 4);
    try_(-1, 3'd2, 4'h0, 0); try_(2, 3'd0, 4'h0, 0); try_(302, 3'd2, 4'h0, 0);
    try_(2, 3'd0, 4'h0, 0); try_(302, 3'd2, 4'h0, 0); try_(2, 3'd0, 4'h0, 0);
    try_(302, 3'd2, 4'h0, 0); run_case(1'b0, 7);

    begin_case("R7 six defers then ACK", 1'b0, 2);
    try_(-1, 3'd0, 4'h2, 0);
    for (int i = 0; i < 5; i++) try_(1002, 3'd0, 4'h2, 0);
    try_(1002, 3'd0, 4'h0, 2); run_case(1'b1, 7);
    begin_case("R7 seventh defer fails", 1'b0, 2);
    try_(-1, 3'd0, 4'h2, 0);
    for (int i = 0; i < 6; i++) try_(1002, 3'd0, 4'h2, 0);
    run_case(1'b0, 7);

    begin_case("R8 I2C defers then ACK", 1'b0, 3);
    try_(-1, 3'd0, 4'h8, 0); try_(1002, 3'd0, 4'h8, 0); try_(1002, 3'd0, 4'h0, 3);
    run_case(1'b1, 3);

    begin_case("R9 timeout after defer", 1'b0, 3);
    try_(-1, 3'd0, 4'h2, 0); try_(1002, 3'd2, 4'h0, 0); try_(1002, 3'd0, 4'h0, 3);
    run_case(1'b1, 3);

    begin_case("R10 short read ACK", 1'b0, 4);
    try_(-1, 3'd0, 4'h0, 2); try_(302, 3'd0, 4'h0, 4); run_case(1'b1, 2);

    begin_case("R11 write status poll", 1'b1, 3);
    try_(-1, 3'd0, 4'h0, 2); try_poll(302, 3'd0, 4'h0, 0); run_case(1'b1, 2);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule